// File: doc/BRIEF.md
# Multi-Speed Serial Clock Phase Generator

This block drives the clock line of a two-wire serial bus master. It counts cycles of the reference clock to form the low and high halves of each clock period. The cycle counts come from three pairs of count inputs: one pair for standard speed, one for fast speed and one for high speed. A two-bit speed field picks the pair. Fast-plus speed has no pair of its own. It uses the fast pair loaded with shorter counts. At a 200 MHz reference, typical counts are 800/940 (high/low) for standard speed, 120/260 for fast, 52/100 for fast-plus and 32/64 for high speed. Any count below 6 is raised to 6.

The controller loads the counts while the block is disabled. The block copies the selected pair, the SDA hold count and the speed choice into shadow registers in the cycle it leaves idle. Changes to these inputs while enabled have no effect until the next enable. The block releases the line and then waits for the sampled line (`scl_in`, passed through a synchronizer) to read high. Only then does it count the high half, so a target that stretches the clock low simply lengthens the period. Strobes mark the first low cycle and the first high cycle for the bit engine. A third strobe marks the cycle in which the data line may change, a programmed number of cycles after each falling edge.

The controller is a four-state machine. IDLE holds the line released and copies the configuration into the shadow registers. IDLE goes to LOW on enable. In LOW the block pulls the line low for the low count, then goes to WAIT. In WAIT the line is released; once the synchronized line reads high the block goes to HIGH. In HIGH the block counts the high count and then returns to LOW. Any state goes back to IDLE when enable drops.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, `scl_o` is 1 (released) and `hi_strobe`, `lo_strobe` and `sda_chg` are 0.
- R2: With speed code 1 (standard), each low phase lasts `std_lo_cnt` cycles of `scl_o` = 0. Each high phase lasts `std_hi_cnt` cycles, counted from the `hi_strobe` cycle up to but not including the next `lo_strobe` cycle.
- R3: Speed code 2 (fast or fast-plus) and speed code 0 both use `fst_hi_cnt`/`fst_lo_cnt`, with the same phase lengths as in R2.
- R4: Speed code 3 (high speed) uses `hs_hi_cnt`/`hs_lo_cnt`, with the same phase lengths as in R2.
- R5: A selected high or low count below 6 acts as 6.
- R6: `hi_strobe` appears only after `scl_in` has been high for SYNC_STAGES+1 consecutive cycles. The number of cycles with `scl_o` = 1 before `hi_strobe` equals the external stretch length plus SYNC_STAGES+1.
- R7: `lo_strobe` marks the first cycle of `scl_o` = 0 after a cycle of `scl_o` = 1. `hi_strobe` marks the first cycle of a high phase. The two strobes are never 1 together.
- R8: `sda_chg` pulses exactly once per low phase, min(`sda_hold_cnt`, L-1) cycles after the `lo_strobe` cycle, where L is the effective low count. A hold count of 0 makes it coincide with `lo_strobe`.
- R9: When `enable` is 0 at a clock edge, from the next cycle `scl_o` is 1 and all strobes are 0.
- R10: The speed code, the count pairs and the hold count are taken in the cycle the block leaves idle. Changes to them while enabled do not alter the phase lengths or the `sda_chg` offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator |
| speed_sel | input | 2 | 1 standard, 2 fast/fast-plus, 3 high speed, 0 treated as fast |
| std_hi_cnt | input | CNT_W | Standard-speed high count |
| std_lo_cnt | input | CNT_W | Standard-speed low count |
| fst_hi_cnt | input | CNT_W | Fast/fast-plus high count |
| fst_lo_cnt | input | CNT_W | Fast/fast-plus low count |
| hs_hi_cnt | input | CNT_W | High-speed high count |
| hs_lo_cnt | input | CNT_W | High-speed low count |
| sda_hold_cnt | input | CNT_W | Cycles from falling edge to data change |
| scl_in | input | 1 | Observed clock line level (asynchronous) |
| scl_o | output | 1 | 0 pulls the clock line low, 1 releases it |
| hi_strobe | output | 1 | First cycle of a high phase |
| lo_strobe | output | 1 | First cycle of a low phase |
| sda_chg | output | 1 | Data line may change in this cycle |

## Verification
A wrong phase counter or a wrong shadow register shows at the ports within one clock period, as a low or high phase of the wrong length. A hold counter fault shows in the same low phase, as an `sda_chg` pulse at the wrong offset, or as a missing or repeated pulse. A fault in the WAIT state's gating shows at the very next rising edge, because the number of released cycles before `hi_strobe` no longer equals the stretch plus the synchronizer delay. A stuck state after enable drops shows one cycle later, as a line held low or a strobe while disabled.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    localparam logic [1:0] SPD_STD  = 2'd1;
    localparam logic [1:0] SPD_FAST = 2'd2;
    localparam logic [1:0] SPD_HS   = 2'd3;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
    import scl_pkg::*;
#(
    parameter int CW   = 16,
    parameter int MINC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [1:0]    speed,
    input  logic [CW-1:0] std_hi,
    input  logic [CW-1:0] std_lo,
    input  logic [CW-1:0] fst_hi,
    input  logic [CW-1:0] fst_lo,
    input  logic [CW-1:0] hs_hi,
    input  logic [CW-1:0] hs_lo,
    input  logic [CW-1:0] hold,
    output logic [CW-1:0] hi_q,
    output logic [CW-1:0] lo_q,
    output logic [CW-1:0] hold_q
);
    localparam logic [CW-1:0] MIN_V = CW'(MINC);

    logic [CW-1:0] sel_hi, sel_lo, hi_c, lo_c, hold_c;

    // pick the pair for the requested speed; code 0 falls back to fast
    always_comb begin
        unique case (speed)
            SPD_STD: begin sel_hi = std_hi; sel_lo = std_lo; end
            SPD_HS:  begin sel_hi = hs_hi;  sel_lo = hs_lo;  end
            default: begin sel_hi = fst_hi; sel_lo = fst_lo; end
        endcase
        hi_c   = (sel_hi < MIN_V) ? MIN_V : sel_hi;
        lo_c   = (sel_lo < MIN_V) ? MIN_V : sel_lo;
        hold_c = (hold > lo_c - 1'b1) ? lo_c - 1'b1 : hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= MIN_V;
            lo_q   <= MIN_V;
            hold_q <= '0;
        end else if (capture) begin
            hi_q   <= hi_c;
            lo_q   <= lo_c;
            hold_q <= hold_c;
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          line_hi,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    input  logic [CW-1:0] hold_cnt,
    output logic          scl_o,
    output logic          hi_strobe,
    output logic          lo_strobe,
    output logic          sda_chg,
    output logic          capture,
    output phase_e        state_o
);
    phase_e        st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            PH_IDLE: if (enable) st_n = PH_LOW;
            PH_LOW: begin
                if (!enable)                     st_n = PH_IDLE;
                else if (cnt == lo_cnt - 1'b1)   st_n = PH_WAIT;
            end
            PH_WAIT: begin
                if (!enable)                     st_n = PH_IDLE;
                else if (line_hi)                st_n = PH_HIGH;
            end
            PH_HIGH: begin
                if (!enable)                     st_n = PH_IDLE;
                else if (cnt == hi_cnt - 1'b1)   st_n = PH_LOW;
            end
        endcase
        if (st_n != st || st_n == PH_IDLE || st_n == PH_WAIT) cnt_n = '0;
        else                                                  cnt_n = cnt + 1'b1;
    end

    always_comb begin
        scl_o     = (st != PH_LOW);
        lo_strobe = (st == PH_LOW)  && (cnt == '0);
        hi_strobe = (st == PH_HIGH) && (cnt == '0);
        sda_chg   = (st == PH_LOW)  && (cnt == hold_cnt);
        capture   = (st == PH_IDLE);
        state_o   = st;
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MIN_CNT     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi_cnt,
    input  logic [CNT_W-1:0] std_lo_cnt,
    input  logic [CNT_W-1:0] fst_hi_cnt,
    input  logic [CNT_W-1:0] fst_lo_cnt,
    input  logic [CNT_W-1:0] hs_hi_cnt,
    input  logic [CNT_W-1:0] hs_lo_cnt,
    input  logic [CNT_W-1:0] sda_hold_cnt,
    input  logic             scl_in,
    output logic             scl_o,
    output logic             hi_strobe,
    output logic             lo_strobe,
    output logic             sda_chg
);
    logic             line_hi, capture;
    logic [CNT_W-1:0] sh_hi, sh_lo, sh_hold;
    phase_e           st_q;
    logic [1:0]       st_bits;

    assign st_bits = st_q;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(line_hi)
    );

    scl_cfg_latch #(.CW(CNT_W), .MINC(MIN_CNT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .capture(capture), .speed(speed_sel),
        .std_hi(std_hi_cnt), .std_lo(std_lo_cnt),
        .fst_hi(fst_hi_cnt), .fst_lo(fst_lo_cnt),
        .hs_hi(hs_hi_cnt),   .hs_lo(hs_lo_cnt),
        .hold(sda_hold_cnt),
        .hi_q(sh_hi), .lo_q(sh_lo), .hold_q(sh_hold)
    );

    scl_phase_fsm #(.CW(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line_hi(line_hi),
        .hi_cnt(sh_hi), .lo_cnt(sh_lo), .hold_cnt(sh_hold),
        .scl_o(scl_o), .hi_strobe(hi_strobe), .lo_strobe(lo_strobe),
        .sda_chg(sda_chg), .capture(capture), .state_o(st_q)
    );
endmodule

// File: rtl/scl_phase_chk.sv
module scl_phase_chk #(
    parameter int CW   = 16,
    parameter int MINC = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          scl_in,
    input logic          scl_o,
    input logic          hi_strobe,
    input logic          lo_strobe,
    input logic          sda_chg,
    input logic [1:0]    st_bits,
    input logic [CW-1:0] sh_hi,
    input logic [CW-1:0] sh_lo,
    input logic [CW-1:0] sh_hold
);
    // R9
    disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !hi_strobe && !lo_strobe && !sda_chg));

    // R7
    fall_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_strobe |-> (!scl_o && $past(scl_o)));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_strobe, lo_strobe}));

    // R6
    high_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_strobe |-> (scl_in && $past(scl_in)));

    // R8
    sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg |-> !scl_o);

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_bits != 2'd0 && $past(st_bits) != 2'd0) |-> $stable({sh_hi, sh_lo, sh_hold}));

    // R5
    min_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_bits != 2'd0) |-> (sh_hi >= CW'(MINC) && sh_lo >= CW'(MINC)));
endmodule

bind scl_phase_gen scl_phase_chk #(.CW(CNT_W), .MINC(MIN_CNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
    .scl_o(scl_o), .hi_strobe(hi_strobe), .lo_strobe(lo_strobe),
    .sda_chg(sda_chg), .st_bits(st_bits),
    .sh_hi(sh_hi), .sh_lo(sh_lo), .sh_hold(sh_hold)
);

// File: tb/sim_scl_phase_gen.sv
`timescale 1ns/1ps
module sim_scl_phase_gen;
    localparam int W    = 16;
    localparam int SYNC = 2;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [1:0] speed_sel = 2'd1;
    logic [W-1:0] std_hi = 16'd10, std_lo = 16'd10, fst_hi = 16'd10, fst_lo = 16'd10;
    logic [W-1:0] hs_hi = 16'd10, hs_lo = 16'd10, hold = 16'd0;
    logic stretch = 1'b0, stretch_nx = 1'b0;
    logic scl_o, hi_strobe, lo_strobe, sda_chg, scl_line;

    assign scl_line = scl_o & ~stretch;
    always #2.5 clk = ~clk;

    scl_phase_gen #(.CNT_W(W), .MIN_CNT(6), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
        .std_hi_cnt(std_hi), .std_lo_cnt(std_lo), .fst_hi_cnt(fst_hi),
        .fst_lo_cnt(fst_lo), .hs_hi_cnt(hs_hi), .hs_lo_cnt(hs_lo),
        .sda_hold_cnt(hold), .scl_in(scl_line), .scl_o(scl_o),
        .hi_strobe(hi_strobe), .lo_strobe(lo_strobe), .sda_chg(sda_chg)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    int exp_hi, exp_lo, exp_hold, str_len;
    string tag;

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    function automatic int eff(int v);
        return (v < 6) ? 6 : v;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: sample at negedge, stretch applied at the next posedge
    bit prev_scl = 1;
    int lowrun = 0, hirun = 0, gap = 0, linerun = 0, sc = 0, sda_off = 0, sda_seen = 0;
    bit in_hi = 0, in_wait = 0, in_low = 0;

    always @(posedge clk) begin
        stretch <= stretch_nx;
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_scl = 1;
        end else if (!enable) begin
            // R9: released and quiet while disabled
            check(scl_o && !hi_strobe && !lo_strobe && !sda_chg, "R9",
                  {scl_o, hi_strobe, lo_strobe, sda_chg}, 4'b1000);
            lowrun = 0; hirun = 0; gap = 0; linerun = 0; sc = 0;
            in_hi = 0; in_wait = 0; in_low = 0; sda_seen = 0;
            stretch_nx <= 1'b0;
            prev_scl = 1;
        end else begin
            check(!(hi_strobe && lo_strobe), "R7", {hi_strobe, lo_strobe}, 0);
            if (lo_strobe) begin
                // R7 falling edge mark
                check(!scl_o && prev_scl, "R7", {scl_o, prev_scl}, 1);
                if (in_hi) check(hirun == exp_hi, {tag, " high"}, hirun, exp_hi);
                in_hi = 0; in_low = 1; sda_off = 0; sda_seen = 0;
                if (str_len > 0) stretch_nx <= 1'b1;
                sc = 0;
            end
            if (!scl_o) begin
                lowrun++;
                if (sda_chg) begin
                    sda_seen++;
                    if (in_low) check(sda_off == exp_hold, "R8 offset", sda_off, exp_hold);
                end
                sda_off++;
            end else if (lowrun > 0) begin
                check(lowrun == exp_lo, {tag, " low"}, lowrun, exp_lo);
                if (in_low) check(sda_seen == 1, "R8 count", sda_seen, 1);
                lowrun = 0; in_low = 0; in_wait = 1; gap = 0;
            end
            if (hi_strobe) begin
                check(scl_o == 1'b1, "R7", scl_o, 1);
                check(linerun == SYNC + 1, "R6 line", linerun, SYNC + 1);
                if (in_wait) check(gap == str_len + SYNC + 1, "R6 gap", gap, str_len + SYNC + 1);
                in_wait = 0; in_hi = 1; hirun = 1;
            end else if (in_hi) hirun++;
            if (in_wait) begin
                gap++;
                if (stretch_nx) begin
                    sc++;
                    if (sc >= str_len) stretch_nx <= 1'b0;
                end
            end
            linerun = scl_line ? linerun + 1 : 0;
            prev_scl = scl_o;
        end
    end

    task automatic randomize_cfg();
        speed_sel = 2'($urandom_range(0, 3));
        std_hi = 16'($urandom_range(2, 40)); std_lo = 16'($urandom_range(2, 40));
        fst_hi = 16'($urandom_range(2, 40)); fst_lo = 16'($urandom_range(2, 40));
        hs_hi  = 16'($urandom_range(2, 40)); hs_lo  = 16'($urandom_range(2, 40));
        hold   = 16'($urandom_range(0, 45));
    endtask

    task automatic run_case(int sl, bit mutate);
        int h, l;
        @(negedge clk); #1 enable = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        case (speed_sel)
            2'd1: begin h = int'(std_hi); l = int'(std_lo); tag = "R2"; end
            2'd3: begin h = int'(hs_hi);  l = int'(hs_lo);  tag = "R4"; end
            default: begin h = int'(fst_hi); l = int'(fst_lo); tag = "R3"; end
        endcase
        if (h < 6 || l < 6) tag = {tag, " R5"};
        if (mutate) tag = {tag, " R10"};
        exp_hi = eff(h); exp_lo = eff(l);
        exp_hold = (int'(hold) > exp_lo - 1) ? exp_lo - 1 : int'(hold);
        str_len = sl;
        enable = 1'b1;
        if (mutate) begin
            repeat (3) @(negedge clk);
            #1 randomize_cfg();
        end
        repeat (3 * (exp_hi + exp_lo + sl + 8)) @(negedge clk);
        #1 enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(logic [1:0] sp, int sh, int slo, int fh, int fl, int hh, int hl, int hd);
        speed_sel = sp;
        std_hi = 16'(sh); std_lo = 16'(slo); fst_hi = 16'(fh); fst_lo = 16'(fl);
        hs_hi = 16'(hh); hs_lo = 16'(hl); hold = 16'(hd);
    endtask

    initial begin
        void'($urandom(32'h5C1A_0007));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(scl_o && !hi_strobe && !lo_strobe && !sda_chg, "R1",
              {scl_o, hi_strobe, lo_strobe, sda_chg}, 4'b1000);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(scl_o && !hi_strobe && !lo_strobe && !sda_chg, "R1",
              {scl_o, hi_strobe, lo_strobe, sda_chg}, 4'b1000);

        // directed: typical counts at 200 MHz for each speed
        set_cfg(2'd1, 800, 940, 120, 260, 32, 64, 60);  run_case(0, 0);  // R2
        set_cfg(2'd2, 800, 940, 120, 260, 32, 64, 30);  run_case(0, 0);  // R3 fast
        set_cfg(2'd2, 800, 940, 52, 100, 32, 64, 20);   run_case(3, 0);  // R3 fast-plus
        set_cfg(2'd3, 800, 940, 120, 260, 32, 64, 5);   run_case(1, 0);  // R4
        set_cfg(2'd0, 9, 9, 14, 11, 7, 7, 2);           run_case(0, 0);  // R3 code 0
        // corners: zero counts clamp (R5), hold 0 and oversized hold (R8), long stretch (R6)
        set_cfg(2'd3, 9, 9, 9, 9, 0, 1, 0);             run_case(0, 0);
        set_cfg(2'd1, 5, 6, 9, 9, 9, 9, 100);           run_case(20, 0);
        set_cfg(2'd2, 9, 9, 7, 8, 9, 9, 7);             run_case(2, 1);  // R10

        for (int i = 0; i < 60; i++) begin
            randomize_cfg();
            run_case(int'($urandom_range(0, 6)), ($urandom_range(0, 1) == 1));
        end
        finish_run();
    end
endmodule